// File: doc/BRIEF.md
# Adaptive Rood Search Position Sequencer

This block steps a block-matching motion search through the candidate points of a rood (cross) shaped pattern centred on a predicted motion vector. A pattern has at most six numbered points: the predicted point, four arm points at the given horizontal and vertical arm lengths, and the zero-motion point written relative to the predictor. Some of these points can land on top of each other. An outside controller works out which points are redundant, marks them in a skip mask, and pulses a start strobe.

From the cycle after that strobe, the sequencer presents one effective point per clock. For each point it gives the point's index and its signed 4-bit x/y offset from the predictor. The counter jumps over any run of skipped points in a single step, so merged points cost no cycles. A done flag marks the last point of the pattern.

A second mode runs the unit rood used for refinement. It has five points with arms of length one, and the zero-motion point does not exist in it. The outside controller starts that mode again for each refinement step until the best point stays at the search centre.

Top module: `rood_seq`

## Requirements
- R1: After reset, `valid` and `done` are low and stay low until the first `start`.
- R2: On the cycle after `start` is sampled high, `valid` is high and `pos` is 0, whatever the value of `skipMask[0]`. Point 0 is never skipped.
- R3: Within a pattern, `pos` takes the indices p in 1..5 whose `skipMask[p]` is 0, in rising order, one per clock. Skipped indices take no cycles.
- R4: `done` is high exactly in the cycle that shows the last effective point. In the next cycle `valid` goes low and stays low until the next `start`.
- R5: In rood mode (`unitMode`=0), the offsets (offX, offY) are as follows: index 0 gives (0,0), 1 gives (+armX,0), 2 gives (0,+armY), 3 gives (-armX,0) and 4 gives (0,-armY). Both are 4-bit two's complement.
- R6: Index 5 gives (-predX, -predY), the zero-motion point relative to the predictor, for predictor components in -7..7.
- R7: In unit mode (`unitMode`=1), the arm offsets use length 1 and the arm inputs are ignored. Index 5 is never visited, even when `skipMask[5]` is 0.
- R8: Mode, arm lengths, predictor and mask are captured at `start`. Changing these inputs during a pattern does not change its points or offsets.
- R9: A `start` during a running pattern abandons that pattern and begins the new one at index 0 in the next cycle.
- R10: A mask with bits 1..5 all set gives a single-cycle pattern: index 0 with `done` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load strobe for a new pattern |
| unitMode | input | 1 | 0 = adaptive rood, 1 = unit rood |
| skipMask | input | 6 | Bit p set skips index p (bit 0 unused) |
| armX | input | 3 | Horizontal arm length, unsigned |
| armY | input | 3 | Vertical arm length, unsigned |
| predX | input | 4 | Predictor x, two's complement |
| predY | input | 4 | Predictor y, two's complement |
| pos | output | 3 | Index of the current point |
| offX | output | 4 | x offset from the predictor, signed |
| offY | output | 4 | y offset from the predictor, signed |
| valid | output | 1 | A point is being presented |
| done | output | 1 | Current point is the pattern's last |

## Verification
The bench uses the default parameters: a six-point pattern with 4-bit offsets and 3-bit arms. At this size, all 64 skip masks can be run in both modes, covering every possible jump length and every position of the last point. Every arm-length pair from 0 to 7 and every predictor component from -7 to 7 is also swept. The expected indices and offsets are computed arithmetically from the mask, and the cycle count of each pattern shows directly whether skipped points took time.

// File: rtl/rood_pkg.sv
package rood_pkg;
  localparam int NPOS  = 6;
  localparam int POS_W = $clog2(NPOS);
  localparam int OFF_W = 4;
  localparam int ARM_W = OFF_W - 1;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrl_t;
endpackage

// File: rtl/rood_ctrl.sv
module rood_ctrl
  import rood_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  start,
  input  logic  lastPt,
  output ctrl_t ctrl,
  output logic  active
);
  always_comb begin
    ctrl.load    = start;
    ctrl.advance = active & ~start & ~lastPt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             active <= 1'b0;
    else if (start)        active <= 1'b1;
    else if (active && lastPt) active <= 1'b0;
  end
endmodule

// File: rtl/rood_dpath.sv
module rood_dpath
  import rood_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic             unitMode,
  input  logic [NPOS-1:0]  skipMask,
  input  logic [ARM_W-1:0] armX,
  input  logic [ARM_W-1:0] armY,
  input  logic [OFF_W-1:0] predX,
  input  logic [OFF_W-1:0] predY,
  output logic [POS_W-1:0] pos,
  output logic [OFF_W-1:0] offX,
  output logic [OFF_W-1:0] offY,
  output logic             lastPt
);
  logic [NPOS-1:0]  skipQ;
  logic [ARM_W-1:0] armXq, armYq;
  logic [OFF_W-1:0] predXq, predYq;
  logic             unitQ;
  logic [POS_W-1:0] incr;
  logic [NPOS-1:0]  skipNext;
  logic [NPOS-1:0]  loadMask;
  logic [OFF_W-1:0] armEx, armEy;

  // Step length: one plus the run of set skip bits above the current point.
  always_comb begin
    logic run;
    run  = 1'b1;
    incr = POS_W'(1);
    for (int i = 1; i < NPOS; i++) begin
      run = run & skipQ[i];
      if (run) incr = incr + POS_W'(1);
    end
  end

  // Points beyond the last index count as skipped.
  assign lastPt   = &skipQ[NPOS-1:1];
  assign skipNext = NPOS'({{NPOS{1'b1}}, skipQ} >> incr);
  assign loadMask = {skipMask[NPOS-1] | unitMode, skipMask[NPOS-2:1], 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos    <= '0;
      skipQ  <= '1;
      armXq  <= '0;
      armYq  <= '0;
      predXq <= '0;
      predYq <= '0;
      unitQ  <= 1'b0;
    end else if (ctrl.load) begin
      pos    <= '0;
      skipQ  <= loadMask;
      armXq  <= armX;
      armYq  <= armY;
      predXq <= predX;
      predYq <= predY;
      unitQ  <= unitMode;
    end else if (ctrl.advance) begin
      pos   <= pos + incr;
      skipQ <= skipNext;
    end
  end

  assign armEx = unitQ ? OFF_W'(1) : OFF_W'(armXq);
  assign armEy = unitQ ? OFF_W'(1) : OFF_W'(armYq);

  always_comb begin
    offX = '0;
    offY = '0;
    case (pos)
      POS_W'(1): offX = armEx;
      POS_W'(2): offY = armEy;
      POS_W'(3): offX = -armEx;
      POS_W'(4): offY = -armEy;
      POS_W'(5): begin
        offX = -predXq;
        offY = -predYq;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rood_seq.sv
module rood_seq
  import rood_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             unitMode,
  input  logic [NPOS-1:0]  skipMask,
  input  logic [ARM_W-1:0] armX,
  input  logic [ARM_W-1:0] armY,
  input  logic [OFF_W-1:0] predX,
  input  logic [OFF_W-1:0] predY,
  output logic [POS_W-1:0] pos,
  output logic [OFF_W-1:0] offX,
  output logic [OFF_W-1:0] offY,
  output logic             valid,
  output logic             done
);
  ctrl_t ctrl;
  logic  lastPt;
  logic  active;

  rood_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .lastPt(lastPt),
    .ctrl(ctrl), .active(active)
  );

  rood_dpath uDpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .unitMode(unitMode),
    .skipMask(skipMask), .armX(armX), .armY(armY),
    .predX(predX), .predY(predY),
    .pos(pos), .offX(offX), .offY(offY), .lastPt(lastPt)
  );

  assign valid = active;
  assign done  = active & lastPt;
endmodule

// File: rtl/rood_seq_chk.sv
module rood_seq_chk
  import rood_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             unitMode,
  input logic [POS_W-1:0] pos,
  input logic [OFF_W-1:0] offX,
  input logic [OFF_W-1:0] offY,
  input logic             valid,
  input logic             done
);
  logic modeQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      modeQ <= 1'b0;
    else if (start) modeQ <= unitMode;
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!valid && !start) |=> !valid);

  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (valid && pos == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !done && !start) |=> (valid && pos > $past(pos)));

  p_done_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !valid);

  p_done_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> valid);

  p_origin_r5: assert property (@(posedge clk) disable iff (!rstN)
    (valid && pos == '0) |-> (offX == '0 && offY == '0));

  p_unit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (valid && modeQ) |-> (pos != POS_W'(5)));
endmodule

bind rood_seq rood_seq_chk uChk (
  .clk(clk), .rstN(rstN), .start(start), .unitMode(unitMode),
  .pos(pos), .offX(offX), .offY(offY), .valid(valid), .done(done)
);

// File: tb/tb_rood_seq.sv
module tb_rood_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       unitMode = 1'b0;
  logic [5:0] skipMask = '0;
  logic [2:0] armX = '0, armY = '0;
  logic [3:0] predX = '0, predY = '0;
  logic [2:0] pos;
  logic [3:0] offX, offY;
  logic       valid, done;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  rood_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .unitMode(unitMode),
    .skipMask(skipMask), .armX(armX), .armY(armY),
    .predX(predX), .predY(predY),
    .pos(pos), .offX(offX), .offY(offY), .valid(valid), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expOff(input int p, input bit isX, input bit um,
                                input int ax, input int ay, input int px, input int py);
    int a, b;
    a = um ? 1 : ax;
    b = um ? 1 : ay;
    case (p)
      1: return isX ? (a & 15) : 0;
      2: return isX ? 0 : (b & 15);
      3: return isX ? ((-a) & 15) : 0;
      4: return isX ? 0 : ((-b) & 15);
      5: return isX ? ((-px) & 15) : ((-py) & 15);
      default: return 0;
    endcase
  endfunction

  // Called at a falling edge; returns at a falling edge after the pattern.
  task automatic runPattern(input logic [5:0] m, input bit um, input int ax,
                            input int ay, input int px, input int py,
                            input bit scramble, input string req);
    int seq[6];
    int n;
    unitMode = um; skipMask = m;
    armX = 3'(ax); armY = 3'(ay); predX = 4'(px); predY = 4'(py);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      unitMode = ~um; skipMask = ~m;
      armX = ~armX; armY = ~armY; predX = ~predX; predY = ~predY;
    end
    n = 0;
    for (int p = 0; p < 6; p++)
      if (p == 0 || (!m[p] && !(um && p == 5))) begin
        seq[n] = p;
        n++;
      end
    for (int k = 0; k < n; k++) begin
      chk(valid == 1'b1, {req, " valid"}, int'(valid), 1);
      chk(int'(pos) == seq[k], {req, " R3 pos"}, int'(pos), seq[k]);
      chk(int'(offX) == expOff(seq[k], 1'b1, um, ax, ay, px, py),
          {req, " R5/R6 offX"}, int'(offX), expOff(seq[k], 1'b1, um, ax, ay, px, py));
      chk(int'(offY) == expOff(seq[k], 1'b0, um, ax, ay, px, py),
          {req, " R5/R6 offY"}, int'(offY), expOff(seq[k], 1'b0, um, ax, ay, px, py));
      chk(done == (k == n - 1), {req, " R4 done"}, int'(done), int'(k == n - 1));
      @(negedge clk);
    end
    chk(valid == 1'b0, {req, " R4 valid after end"}, int'(valid), 0);
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    nFail++;
    $display("FAIL watchdog: actual %0d expected <200000", cycles);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(valid == 1'b0 && done == 1'b0, "R1 in reset", int'(valid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(valid == 1'b0 && done == 1'b0, "R1 idle after reset", int'(valid), 0);

    // R3 R4 R7 R2: every mask in both modes; R10 covered by mask bits 1..5 set
    for (int um = 0; um < 2; um++)
      for (int m = 0; m < 64; m++)
        runPattern(6'(m), um[0], 3, 5, 2, -3, 1'b0, um ? "R7 mask" : "R3 mask");

    // R10: all skipped, bit 0 also set (R2: bit 0 ignored)
    runPattern(6'b111111, 1'b0, 7, 7, 1, 1, 1'b0, "R10 single");

    // R5: every arm length pair
    for (int ax = 0; ax < 8; ax++)
      for (int ay = 0; ay < 8; ay++)
        runPattern(6'b100000, 1'b0, ax, ay, 0, 0, 1'b0, "R5 arms");

    // R6: every predictor component in -7..7
    for (int px = -7; px < 8; px++)
      for (int py = -7; py < 8; py++)
        runPattern(6'b011110, 1'b0, 2, 2, px, py, 1'b0, "R6 pred");

    // R7: unit mode ignores arm inputs
    runPattern(6'b000000, 1'b1, 6, 4, 3, 3, 1'b0, "R7 arms ignored");

    // R8: inputs changed right after start
    runPattern(6'b000000, 1'b0, 3, 5, 2, -3, 1'b1, "R8 latched");
    runPattern(6'b001010, 1'b1, 0, 0, 4, 4, 1'b1, "R8 latched unit");

    // R9: restart in the middle of a pattern
    unitMode = 1'b0; skipMask = 6'b000000; armX = 3'd2; armY = 3'd2;
    predX = 4'd1; predY = 4'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(int'(pos) == 2, "R9 before restart pos", int'(pos), 2);
    runPattern(6'b011110, 1'b0, 4, 4, -2, 5, 1'b0, "R9 restart");

    repeat (2) @(negedge clk);
    chk(valid == 1'b0, "R4 idle at end", int'(valid), 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule